// File: doc/BRIEF.md
# Packed Character Load/Deposit Unit

This block is the character path of an 18-bit accumulator machine whose words each hold three 6-bit characters. A caller hands it a command, either load or deposit, together with an indirect pointer word, the accumulator and, one cycle later, the addressed memory word. The top two bits of the pointer word hold a character code. The low twelve bits hold the word address. The four bits between them pass through untouched.

The unit works in two internal cycles. The first is the pointer cycle. In auto-increment mode it advances the character code and, when the code wraps, it also advances the address. It then presents the updated pointer word so the caller can fetch the target word and write the pointer back. The second is the character cycle. Here the unit extracts a character into the accumulator, or it inserts the leading accumulator character into the memory word and rotates the accumulator. A one-cycle done pulse closes the operation. While auto-increment runs, an output tells the interrupt logic that no break may fall between the two cycles. An optional ring setting keeps address advancement inside an aligned group of eight words.

Top module: `char_ld_dep`

## Requirements
- R1: A load places the selected character in accumulator bits 17:12 and clears bits 11:0. Character one is bits 17:12, character two is bits 11:6 and character three is bits 5:0 of the memory word.
- R2: A deposit returns the memory word with the selected slot replaced by accumulator bits 17:12 and the other two slots unchanged, and raises mem_we_o together with done_o.
- R3: A deposit returns the accumulator rotated left by six bits: bits 11:0 move to 17:6 and the old bits 17:12 go to bits 5:0.
- R4: A load never raises mem_we_o, and mem_o then equals the memory word that was read.
- R5: Without auto-increment, pointer codes 01, 10 and 11 (bits 17:16) select characters one, two and three, and code 00 acts as 01. The pointer word comes back unchanged and ptr_we_o stays low.
- R6: With auto-increment, the code advances before the access (00 to 01, 01 to 10, 10 to 11). The advanced code selects the character. The updated pointer word is shown on ptr_word_o during the character cycle, with ptr_we_o high for that one cycle.
- R7: With auto-increment, code 11 becomes 01 and the 12-bit address (bits 11:0) goes up by one, wrapping at 4095. Bits 15:12 are unchanged.
- R8: With ring_i set, an address advance changes only address bits 2:0, which wrap from 7 to 0. Bits 11:3 stay as they were.
- R9: A command accepted at clock edge k yields ptr_word_o after edge k+1 and acc_o, mem_o and done_o after edge k+2. mem_word_i is sampled at edge k+2. done_o is high for exactly one cycle.
- R10: start_i is ignored while busy_o is high. No second operation starts and no extra done pulse appears.
- R11: no_irq_o is high from acceptance through the character cycle when auto-increment is on, and low at all other times.
- R12: After reset, done_o, mem_we_o, ptr_we_o, busy_o and no_irq_o are low and acc_o, mem_o and ptr_word_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command strobe, taken only when idle |
| op_i | input | 1 | 0 = load, 1 = deposit |
| auto_i | input | 1 | Auto-increment mode |
| ring_i | input | 1 | Ring addressing for advances |
| ptr_word_i | input | 18 | Indirect pointer word (code 17:16, address 11:0) |
| acc_i | input | 18 | Accumulator value |
| mem_word_i | input | 18 | Target memory word, sampled in the character cycle |
| acc_o | output | 18 | New accumulator |
| mem_o | output | 18 | New memory word |
| mem_we_o | output | 1 | Memory write strobe (deposit) |
| ptr_word_o | output | 18 | Updated pointer word |
| ptr_we_o | output | 1 | Pointer write-back strobe |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in progress |
| no_irq_o | output | 1 | Interrupt inhibit between the two cycles |

## Verification
The bench walks an auto-increment chain from code 00 through the 11 wrap. A design that advanced after the access, or that did not carry, would load the wrong slot or fail to step the address. It drives the address at 4095 and, under ring mode, at a low field of 7, where a full-width carry would corrupt bits 11:3. It checks code 00 without auto-increment, where a missing mapping would pick no slot or slot three. It also holds start high through a busy operation, which would expose a second done pulse or a clobbered result.

// File: rtl/char_ld_dep_pkg.sv
package char_ld_dep_pkg;
  typedef enum logic {OP_LOAD = 1'b0, OP_DEP = 1'b1} op_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_DEFER = 2'd1, S_CHAR = 2'd2} state_e;
endpackage

// File: rtl/char_ptr_step.sv
module char_ptr_step #(
  parameter int WORD_W = 18,
  parameter int PTR_W  = 2,
  parameter int ADDR_W = 12,
  parameter int RING_W = 3,
  parameter int NCHAR  = 3
) (
  input  logic [WORD_W-1:0] ptr_i,
  input  logic              auto_i,
  input  logic              ring_i,
  output logic [WORD_W-1:0] ptr_o,
  output logic [PTR_W-1:0]  sel_o
);
  localparam int PL = WORD_W - PTR_W;

  logic [PTR_W-1:0]  code, code_n;
  logic [ADDR_W-1:0] addr, addr_n;
  logic              wrap;

  always_comb begin
    code   = ptr_i[WORD_W-1:PL];
    addr   = ptr_i[ADDR_W-1:0];
    code_n = code;
    wrap   = 1'b0;
    if (auto_i) begin
      if (code == PTR_W'(NCHAR)) begin
        code_n = PTR_W'(1);
        wrap   = 1'b1;
      end else begin
        code_n = code + PTR_W'(1);
      end
    end else if (code == '0) begin
      code_n = PTR_W'(1);
    end
    addr_n = addr;
    if (wrap) begin
      if (ring_i) addr_n = {addr[ADDR_W-1:RING_W], addr[RING_W-1:0] + RING_W'(1)};
      else        addr_n = addr + ADDR_W'(1);
    end
    ptr_o = ptr_i;
    if (auto_i) begin
      ptr_o[WORD_W-1:PL]  = code_n;
      ptr_o[ADDR_W-1:0]   = addr_n;
    end
    sel_o = code_n - PTR_W'(1);
  end
endmodule

// File: rtl/char_slot_alu.sv
module char_slot_alu #(
  parameter int WORD_W = 18,
  parameter int CHAR_W = 6,
  parameter int NCHAR  = 3,
  parameter int PTR_W  = 2
) (
  input  logic              dep_i,
  input  logic [PTR_W-1:0]  sel_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] mem_i,
  output logic [WORD_W-1:0] acc_o,
  output logic [WORD_W-1:0] mem_o
);
  localparam int TOP = WORD_W - CHAR_W;

  logic [CHAR_W-1:0] slot [NCHAR];
  logic [CHAR_W-1:0] picked;

  for (genvar k = 0; k < NCHAR; k++) begin : g_slot
    localparam int LO = WORD_W - (k + 1) * CHAR_W;
    assign slot[k] = mem_i[LO +: CHAR_W];
    assign mem_o[LO +: CHAR_W] = (dep_i && sel_i == PTR_W'(k)) ? acc_i[TOP +: CHAR_W]
                                                               : mem_i[LO +: CHAR_W];
  end

  always_comb begin
    picked = '0;
    for (int k = 0; k < NCHAR; k++)
      if (sel_i == PTR_W'(k)) picked = slot[k];
    acc_o = dep_i ? {acc_i[TOP-1:0], acc_i[WORD_W-1 -: CHAR_W]}
                  : {picked, {TOP{1'b0}}};
  end
endmodule

// File: rtl/char_ld_dep.sv
module char_ld_dep
  import char_ld_dep_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int CHAR_W = 6,
  parameter int PTR_W  = 2,
  parameter int ADDR_W = 12,
  parameter int RING_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              op_i,
  input  logic              auto_i,
  input  logic              ring_i,
  input  logic [WORD_W-1:0] ptr_word_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] mem_word_i,
  output logic [WORD_W-1:0] acc_o,
  output logic [WORD_W-1:0] mem_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] ptr_word_o,
  output logic              ptr_we_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              no_irq_o
);
  localparam int NCHAR = WORD_W / CHAR_W;

  state_e            state;
  op_e               op_q;
  logic              auto_q, ring_q;
  logic [WORD_W-1:0] ptr_q, acc_q;
  logic [PTR_W-1:0]  sel_q, sel_n;
  logic [WORD_W-1:0] ptr_n, acc_n, mem_n;

  char_ptr_step #(.WORD_W(WORD_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W),
                  .RING_W(RING_W), .NCHAR(NCHAR)) u_step (
    .ptr_i(ptr_q), .auto_i(auto_q), .ring_i(ring_q), .ptr_o(ptr_n), .sel_o(sel_n));

  char_slot_alu #(.WORD_W(WORD_W), .CHAR_W(CHAR_W), .NCHAR(NCHAR), .PTR_W(PTR_W)) u_alu (
    .dep_i(op_q == OP_DEP), .sel_i(sel_q), .acc_i(acc_q), .mem_i(mem_word_i),
    .acc_o(acc_n), .mem_o(mem_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_q       <= OP_LOAD;
      auto_q     <= 1'b0;
      ring_q     <= 1'b0;
      ptr_q      <= '0;
      acc_q      <= '0;
      sel_q      <= '0;
      acc_o      <= '0;
      mem_o      <= '0;
      ptr_word_o <= '0;
      mem_we_o   <= 1'b0;
      ptr_we_o   <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      mem_we_o <= 1'b0;
      ptr_we_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          op_q   <= op_e'(op_i);
          auto_q <= auto_i;
          ring_q <= ring_i;
          ptr_q  <= ptr_word_i;
          acc_q  <= acc_i;
          state  <= S_DEFER;
        end
        S_DEFER: begin
          ptr_word_o <= ptr_n;
          ptr_we_o   <= auto_q;
          sel_q      <= sel_n;
          state      <= S_CHAR;
        end
        S_CHAR: begin
          acc_o    <= acc_n;
          mem_o    <= mem_n;
          mem_we_o <= (op_q == OP_DEP);
          done_o   <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (state != S_IDLE);
  assign no_irq_o = busy_o && auto_q;

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r9_done_after_char: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(state == S_CHAR));
  a_r2_write_with_done: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> done_o);
  a_r4_load_no_write: assert property (@(posedge clk) disable iff (rst)
    (done_o && op_q == OP_LOAD) |-> !mem_we_o);
  a_r3_rotate: assert property (@(posedge clk) disable iff (rst)
    (done_o && op_q == OP_DEP) |-> acc_o == {acc_q[WORD_W-CHAR_W-1:0], acc_q[WORD_W-1 -: CHAR_W]});
  a_r6_ptr_we_auto: assert property (@(posedge clk) disable iff (rst)
    ptr_we_o |-> (auto_q && state == S_CHAR));
  a_r8_ring_high_kept: assert property (@(posedge clk) disable iff (rst)
    (ptr_we_o && ring_q) |-> ptr_word_o[ADDR_W-1:RING_W] == ptr_q[ADDR_W-1:RING_W]);
  a_r10_no_reentry: assert property (@(posedge clk) disable iff (rst)
    (state == S_CHAR) |=> (state == S_IDLE));
  a_r11_inhibit_start: assert property (@(posedge clk) disable iff (rst)
    $rose(no_irq_o) |-> (state == S_DEFER));
endmodule

// File: tb/char_ld_dep_tb_top.sv
`timescale 1ns/1ps
module char_ld_dep_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, op_i = 0, auto_i = 0, ring_i = 0;
  logic [17:0] ptr_word_i = '0, acc_i = '0, mem_word_i = '0;
  logic [17:0] acc_o, mem_o, ptr_word_o;
  logic mem_we_o, ptr_we_o, done_o, busy_o, no_irq_o;
  int checks = 0, errs = 0;

  always #2.5 clk = ~clk;

  char_ld_dep dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input bit op, input bit au, input bit rg,
      input logic [17:0] p, input logic [17:0] m, input logic [17:0] a,
      output logic [17:0] ep, output logic [17:0] ea, output logic [17:0] em);
    int c = int'(p[17:16]);
    int sh;
    logic [11:0] ad = p[11:0];
    logic [5:0] ch;
    if (au) begin
      if (c == 3) begin
        c = 1;
        if (rg) ad = {ad[11:3], 3'(ad[2:0] + 3'd1)};
        else    ad = ad + 12'd1;
      end else c = c + 1;
      ep = {2'(c), p[15:12], ad};
    end else begin
      ep = p;
      if (c == 0) c = 1;
    end
    sh = (3 - c) * 6;
    ch = 6'(m >> sh);
    if (!op) begin
      ea = {ch, 12'b0};
      em = m;
    end else begin
      em = (m & ~(18'h3f << sh)) | (18'(a[17:12]) << sh);
      ea = {a[11:0], a[17:12]};
    end
  endfunction

  task automatic run(input bit op, input bit au, input bit rg,
      input logic [17:0] p, input logic [17:0] m, input logic [17:0] a,
      input bit poke, input string tag);
    logic [17:0] ep, ea, em;
    model(op, au, rg, p, m, a, ep, ea, em);
    @(negedge clk);
    op_i = op; auto_i = au; ring_i = rg; ptr_word_i = p; mem_word_i = m; acc_i = a; start_i = 1;
    @(negedge clk);
    start_i = poke;
    if (poke) begin op_i = ~op; acc_i = ~a; ptr_word_i = ~p; end
    chk(no_irq_o == au && busy_o, {tag, " R11 inhibit in pointer cycle"}, no_irq_o, au);
    @(negedge clk);
    chk(ptr_word_o == ep, {tag, " R5/R6/R7/R8 pointer word"}, ptr_word_o, ep);
    chk(ptr_we_o == au, {tag, " R6 pointer strobe"}, ptr_we_o, au);
    chk(no_irq_o == au, {tag, " R11 inhibit in char cycle"}, no_irq_o, au);
    @(negedge clk);
    start_i = 0;
    chk(done_o == 1'b1, {tag, " R9 done"}, done_o, 1);
    chk(acc_o == ea, {tag, op ? " R3 rotated acc" : " R1 loaded acc"}, acc_o, ea);
    chk(mem_o == em, {tag, op ? " R2 deposited word" : " R4 word unchanged"}, mem_o, em);
    chk(mem_we_o == op, {tag, " R2/R4 write strobe"}, mem_we_o, op);
    chk(no_irq_o == 1'b0, {tag, " R11 inhibit released"}, no_irq_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, {tag, " R9 single pulse"}, done_o, 0);
    if (poke) begin
      @(negedge clk);
      chk(done_o == 1'b0 && busy_o == 1'b0, {tag, " R10 start ignored while busy"}, {done_o, busy_o}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    logic [17:0] p;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(done_o == 0 && mem_we_o == 0 && ptr_we_o == 0 && busy_o == 0 && no_irq_o == 0,
        "R12 reset strobes", {done_o, mem_we_o, ptr_we_o, busy_o, no_irq_o}, 0);
    chk(acc_o == 0 && mem_o == 0 && ptr_word_o == 0, "R12 reset data", acc_o | mem_o | ptr_word_o, 0);
    // R1 R5: loads of each code without auto-increment, including 00
    for (int c = 0; c < 4; c++)
      run(0, 0, 0, {2'(c), 4'h5, 12'o1234}, 18'o112233, 18'o777777, 0, "R1 R5 load");
    // R2 R3: deposits of each code
    for (int c = 1; c < 4; c++)
      run(1, 0, 0, {2'(c), 4'h0, 12'o0100}, 18'o445566, 18'o010203, 0, "R2 R3 deposit");
    // R6 R7: auto chain from 00 through the wrap
    p = {2'b00, 4'hA, 12'o0007};
    for (int i = 0; i < 5; i++) begin
      run(1, 1, 0, p, 18'o000000, 18'o212223, 0, "R6 R7 auto chain");
      p = ptr_word_o;
    end
    run(0, 1, 0, {2'b11, 4'h3, 12'hFFF}, 18'o707172, 18'o0, 0, "R7 address wrap");
    // R8: ring mode confines the advance
    run(0, 1, 1, {2'b11, 4'h0, 12'o1237}, 18'o303132, 18'o0, 0, "R8 ring wrap");
    run(1, 1, 1, {2'b11, 4'h0, 12'o4562}, 18'o303132, 18'o414243, 0, "R8 ring step");
    // R10: start held high through a busy operation
    run(1, 1, 0, {2'b01, 4'h0, 12'o0050}, 18'o123456, 18'o654321, 1, "R10 busy");
    for (int i = 0; i < 300; i++)
      run(1'($urandom), 1'($urandom), 1'($urandom), 18'($urandom), 18'($urandom),
          18'($urandom), (i % 37) == 0, "random");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule